// File: doc/BRIEF.md
# Parallel Packet Bus Host Sequencer

This block drives the host side of an eight-bit parallel bus with a flow-control handshake. Local logic hands it one request: read or write, a byte count and a stream of write bytes. The block then opens a packet by pulling the active-low packet-start line down, moves each byte with a falling strobe edge, and waits for the device's busy line to rise and fall again after every byte. Read bytes come back one at a time. Write bytes are pulled from the local stream with a pop pulse.

Before it moves any line, the sequencer checks that busy is low. It closes the packet only after busy has dropped. It then samples the device's error line and ends with a one-cycle done pulse that carries the status and the number of bytes completed. A wait on busy that lasts too long ends the operation with a timeout. A timeout releases the packet-start line immediately. All bus inputs are taken as synchronous to `clk`.

Top module: `pbm_host`

## Requirements
- R1: Out of reset, packet-start and strobe are high, the direction line is low (write), the data output enable is low, done is low and the request input is ready.
- R2: Packet-start falls, strobe falls, and the direction or data lines change only on a clock edge where busy is sampled low. The one exception is the release caused by a timeout.
- R3: For a write, the direction line is low, the byte is on the data lines with output enable high at least one cycle before the strobe falls, the strobe stays low for exactly STB_CYC cycles, and the device receives the bytes in stream order with one pop pulse per byte.
- R4: For a read, the direction line is high and the output enable is low. The value on the data inputs is returned on rd_data with a one-cycle rd_valid, 1+SETTLE cycles after the cycle in which busy was last seen high.
- R5: After each strobe fall, the next strobe fall or packet release waits until busy has been seen high and is then seen low.
- R6: Packet-start returns high only with busy low after the last byte. A request with a count of 0 opens and closes a packet with no strobe.
- R7: If any wait for busy lasts TIMEOUT cycles, packet-start and strobe go high and the done status shows a timeout with done_ok low. done_count gives the bytes fully completed.
- R8: done pulses for one cycle, exactly one cycle after packet-start returns high. It carries done_err equal to the error input sampled in that cycle, and done_ok high only when there was neither a timeout nor an error.
- R9: The strobe is low only while packet-start is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_read | input | 1 | 1 = read from device, 0 = write to device |
| req_count | input | CNT_W | Bytes in the packet |
| req_ready | output | 1 | Sequencer idle; request accepted when valid and ready |
| wr_data | input | DATA_W | Head of the local write stream |
| wr_pop | output | 1 | Head byte taken |
| rd_data | output | DATA_W | Byte read from device |
| rd_valid | output | 1 | rd_data valid |
| done | output | 1 | Operation finished (one cycle) |
| done_ok | output | 1 | Finished without timeout or error |
| done_timeout | output | 1 | Busy wait timed out |
| done_err | output | 1 | Device error line was high |
| done_count | output | CNT_W | Bytes completed |
| bus_sop_n | output | 1 | Packet-start, active low |
| bus_stb_n | output | 1 | Byte strobe, active low |
| bus_rnw | output | 1 | Direction: 1 read, 0 write |
| bus_dout | output | DATA_W | Write data to bus |
| bus_doe | output | 1 | Drive enable for bus_dout |
| bus_din | input | DATA_W | Read data from bus |
| bus_busy | input | 1 | Device busy |
| bus_error | input | 1 | Device error flag |

## Verification
The bench builds the block with CNT_W=3, STB_CYC=2, SETTLE=2 and TIMEOUT=16. The three-bit count lets a full seven-byte packet and an empty packet both run in a short test. A two-cycle strobe lets a fast device raise busy while the strobe is still low, which checks the busy-seen tracking across that phase. The sixteen-cycle timeout is long enough for slow device responses yet short enough that a device holding busy high forever ends in a timeout after a handful of cycles.

// File: rtl/pbm_pkg.sv
package pbm_pkg;
    typedef enum logic [2:0] {
        PS_IDLE,
        PS_OPEN,
        PS_NEXT,
        PS_STROBE,
        PS_WAITB,
        PS_SETTLE,
        PS_FIN
    } pstate_e;
endpackage

// File: rtl/pbm_wait_timer.sv
module pbm_wait_timer #(
    parameter int LIMIT = 1000,
    localparam int W = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    logic [W-1:0] cnt_q, cnt_d;

    assign expired = run && (cnt_q == W'(LIMIT - 1));

    always_comb begin
        cnt_d = cnt_q;
        if (!run)         cnt_d = '0;
        else if (!expired) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    AST_TMR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < W'(LIMIT)); // R7
    AST_TMR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt_q == '0)); // R7
endmodule

// File: rtl/pbm_host.sv
module pbm_host
    import pbm_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int CNT_W   = 4,
    parameter int STB_CYC = 3,
    parameter int SETTLE  = 2,
    parameter int TIMEOUT = 1000,
    localparam int MAXC   = (STB_CYC > SETTLE) ? STB_CYC : SETTLE,
    localparam int SUB_W  = $clog2(MAXC + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_read,
    input  logic [CNT_W-1:0]  req_count,
    output logic              req_ready,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_pop,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              done,
    output logic              done_ok,
    output logic              done_timeout,
    output logic              done_err,
    output logic [CNT_W-1:0]  done_count,
    output logic              bus_sop_n,
    output logic              bus_stb_n,
    output logic              bus_rnw,
    output logic [DATA_W-1:0] bus_dout,
    output logic              bus_doe,
    input  logic [DATA_W-1:0] bus_din,
    input  logic              bus_busy,
    input  logic              bus_error
);
    typedef struct packed {
        pstate_e           st;
        logic              dir;
        logic              rnw;
        logic              sop_n;
        logic              stb_n;
        logic              doe;
        logic [DATA_W-1:0] dout;
        logic [CNT_W-1:0]  cnt;
        logic [CNT_W-1:0]  total;
        logic [SUB_W-1:0]  sub;
        logic              seen_hi;
        logic              tmo;
        logic              done;
        logic              ok;
        logic              err;
        logic              rd_v;
        logic              pop;
        logic [DATA_W-1:0] rd;
    } regs_t;

    localparam regs_t RESET_VAL = '{
        st: PS_IDLE, dir: 1'b0, rnw: 1'b0, sop_n: 1'b1, stb_n: 1'b1,
        doe: 1'b0, dout: '0, cnt: '0, total: '0, sub: '0, seen_hi: 1'b0,
        tmo: 1'b0, done: 1'b0, ok: 1'b0, err: 1'b0, rd_v: 1'b0, pop: 1'b0,
        rd: '0
    };

    regs_t r_q, r_d;
    logic  waiting;
    logic  tmo_hit;

    // Cycles spent blocked on the busy line
    always_comb begin
        case (r_q.st)
            PS_OPEN, PS_NEXT: waiting = bus_busy;
            PS_STROBE:        waiting = r_q.stb_n && bus_busy;
            PS_WAITB:         waiting = !(r_q.seen_hi && !bus_busy);
            default:          waiting = 1'b0;
        endcase
    end

    pbm_wait_timer #(.LIMIT(TIMEOUT)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (waiting),
        .expired (tmo_hit)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.rd_v = 1'b0;
        r_d.pop  = 1'b0;
        case (r_q.st)
            PS_IDLE: begin
                if (req_valid) begin
                    r_d.dir   = req_read;
                    r_d.total = req_count;
                    r_d.cnt   = '0;
                    r_d.tmo   = 1'b0;
                    r_d.st    = PS_OPEN;
                end
            end
            PS_OPEN: begin
                if (!bus_busy) begin
                    r_d.rnw   = r_q.dir;
                    r_d.sop_n = 1'b0;
                    r_d.doe   = !r_q.dir;
                    r_d.st    = PS_NEXT;
                end
            end
            PS_NEXT: begin
                if (!bus_busy) begin
                    if (r_q.cnt == r_q.total) begin
                        r_d.sop_n = 1'b1;
                        r_d.doe   = 1'b0;
                        r_d.st    = PS_FIN;
                    end else begin
                        if (!r_q.dir) begin
                            r_d.dout = wr_data;
                            r_d.pop  = 1'b1;
                        end
                        r_d.st = PS_STROBE;
                    end
                end
            end
            PS_STROBE: begin
                if (r_q.stb_n) begin
                    if (!bus_busy) begin
                        r_d.stb_n   = 1'b0;
                        r_d.sub     = '0;
                        r_d.seen_hi = 1'b0;
                    end
                end else begin
                    r_d.seen_hi = r_q.seen_hi | bus_busy;
                    if (r_q.sub == SUB_W'(STB_CYC - 1)) begin
                        r_d.stb_n = 1'b1;
                        r_d.st    = PS_WAITB;
                    end else begin
                        r_d.sub = r_q.sub + 1'b1;
                    end
                end
            end
            PS_WAITB: begin
                r_d.seen_hi = r_q.seen_hi | bus_busy;
                if (r_q.seen_hi && !bus_busy) begin
                    if (r_q.dir) begin
                        r_d.sub = '0;
                        r_d.st  = PS_SETTLE;
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                        r_d.st  = PS_NEXT;
                    end
                end
            end
            PS_SETTLE: begin
                if (r_q.sub == SUB_W'(SETTLE - 1)) begin
                    r_d.rd   = bus_din;
                    r_d.rd_v = 1'b1;
                    r_d.cnt  = r_q.cnt + 1'b1;
                    r_d.st   = PS_NEXT;
                end else begin
                    r_d.sub = r_q.sub + 1'b1;
                end
            end
            PS_FIN: begin
                r_d.done = 1'b1;
                r_d.err  = bus_error;
                r_d.ok   = !r_q.tmo && !bus_error;
                r_d.st   = PS_IDLE;
            end
            default: r_d.st = PS_IDLE;
        endcase
        if (tmo_hit) begin
            r_d.tmo   = 1'b1;
            r_d.sop_n = 1'b1;
            r_d.stb_n = 1'b1;
            r_d.doe   = 1'b0;
            r_d.st    = PS_FIN;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= RESET_VAL;
        else        r_q <= r_d;
    end

    assign req_ready    = (r_q.st == PS_IDLE);
    assign wr_pop       = r_q.pop;
    assign rd_data      = r_q.rd;
    assign rd_valid     = r_q.rd_v;
    assign done         = r_q.done;
    assign done_ok      = r_q.ok;
    assign done_timeout = r_q.tmo;
    assign done_err     = r_q.err;
    assign done_count   = r_q.cnt;
    assign bus_sop_n    = r_q.sop_n;
    assign bus_stb_n    = r_q.stb_n;
    assign bus_rnw      = r_q.rnw;
    assign bus_dout     = r_q.dout;
    assign bus_doe      = r_q.doe;

    AST_SOP_FALL_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_sop_n) |-> !$past(bus_busy)); // R2
    AST_STB_FALL_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_stb_n) |-> !$past(bus_busy)); // R2
    AST_WR_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(bus_stb_n) && !bus_rnw) |-> ($past(bus_doe) && $stable(bus_dout))); // R3
    AST_READ_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (bus_rnw && !bus_doe)); // R4
    AST_SOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(bus_sop_n) && !done_timeout) |-> !$past(bus_busy)); // R6
    AST_DONE_AFTER_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (bus_sop_n && $past(bus_sop_n) && bus_stb_n)); // R8
    AST_STB_IN_PKT: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_stb_n |-> !bus_sop_n); // R9
endmodule

// File: tb/pbm_host_bench.sv
`timescale 1ns/1ps
module pbm_host_bench;
    localparam int DW   = 8;
    localparam int CW   = 3;
    localparam int STB  = 2;
    localparam int SETL = 2;
    localparam int TMO  = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_read = 1'b0;
    logic [CW-1:0] req_count = '0;
    logic          req_ready;
    logic [DW-1:0] wr_data = '0;
    logic          wr_pop;
    logic [DW-1:0] rd_data;
    logic          rd_valid;
    logic          done, done_ok, done_timeout, done_err;
    logic [CW-1:0] done_count;
    logic          bus_sop_n, bus_stb_n, bus_rnw, bus_doe;
    logic [DW-1:0] bus_dout;
    logic [DW-1:0] bus_din = '0;
    logic          bus_busy = 1'b0;
    logic          bus_error = 1'b0;

    always #2.5 clk = ~clk;

    pbm_host #(.DATA_W(DW), .CNT_W(CW), .STB_CYC(STB), .SETTLE(SETL), .TIMEOUT(TMO)) u_pbm_host (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_read(req_read),
        .req_count(req_count), .req_ready(req_ready), .wr_data(wr_data),
        .wr_pop(wr_pop), .rd_data(rd_data), .rd_valid(rd_valid), .done(done),
        .done_ok(done_ok), .done_timeout(done_timeout), .done_err(done_err),
        .done_count(done_count), .bus_sop_n(bus_sop_n), .bus_stb_n(bus_stb_n),
        .bus_rnw(bus_rnw), .bus_dout(bus_dout), .bus_doe(bus_doe),
        .bus_din(bus_din), .bus_busy(bus_busy), .bus_error(bus_error)
    );

    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(input bit c, input string rq, input int act, input int expv);
        n_chk++;
        if (!c) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, expv);
        end
    endtask

    // behavioural device and per-cycle protocol model
    logic [DW-1:0] wr_q[$];
    logic [DW-1:0] rx[$];
    logic [DW-1:0] exp_rd[$];
    int cyc = 0, fall_idx = 0, sop_rise_idx = 0;
    int dev_wait = 0, hold = 0, nbytes = 0, stuck_at = -1, pre_hold = 0;
    int dly_cfg = 1, hold_cfg = 2, nstb = 0, npop = 0, low_run = 0;
    bit exp_tmo = 0, pend = 0, hi = 0;
    logic p_sop = 1'b1, p_stb = 1'b1, p_rnw = 1'b0;
    logic [DW-1:0] p_dout = '0;
    logic p_doe = 1'b0;

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (p_sop && !bus_sop_n) chk(!bus_busy, "R2 packet-start fell with busy high", bus_busy, 0);
            if (p_rnw != bus_rnw || p_dout != bus_dout)
                chk(!bus_busy, "R2 direction/data moved with busy high", bus_busy, 0);
            if (!bus_stb_n) begin
                chk(!bus_sop_n, "R9 strobe low outside packet", bus_sop_n, 0);
                low_run++;
            end
            if (p_stb && !bus_stb_n) begin
                chk(!bus_busy, "R2 strobe fell with busy high", bus_busy, 0);
                if (!bus_rnw) begin
                    chk(p_doe && bus_doe && p_dout == bus_dout, "R3 write data setup", int'(p_doe), 1);
                    rx.push_back(bus_dout);
                end
                if (pend) chk(hi && !bus_busy, "R5 strobe before busy cycle", int'(hi), 1);
                pend = 1; hi = 0; low_run = 1; nstb++;
                dev_wait = dly_cfg;
            end
            if (!p_stb && bus_stb_n) chk(low_run == STB, "R3 strobe low width", low_run, STB);
            if (!p_sop && bus_sop_n) begin
                sop_rise_idx = cyc;
                if (bus_busy) exp_tmo = 1;
                else if (pend) chk(hi, "R5 packet closed before busy cycle", int'(hi), 1);
                pend = 0;
            end
            if (bus_busy) hi = 1;
            if (wr_pop) begin
                npop++;
                if (wr_q.size() > 0) void'(wr_q.pop_front());
            end
            wr_data = (wr_q.size() > 0) ? wr_q[0] : '0;
            if (rd_valid) begin
                chk(cyc - fall_idx == 1 + SETL, "R4 read capture timing", cyc - fall_idx, 1 + SETL);
                chk(bus_rnw && !bus_doe, "R4 read direction", int'(bus_rnw), 1);
                if (exp_rd.size() > 0) begin
                    chk(rd_data == exp_rd[0], "R4 read data", rd_data, exp_rd[0]);
                    void'(exp_rd.pop_front());
                end else chk(0, "R4 unexpected read byte", rd_data, 0);
            end
            if (done) chk(cyc - sop_rise_idx == 1, "R8 done one cycle after release", cyc - sop_rise_idx, 1);
            // device response
            if (dev_wait > 0) begin
                dev_wait--;
                if (dev_wait == 0) begin
                    bus_busy = 1'b1; hold = hold_cfg; nbytes++;
                    if (bus_rnw) begin
                        bus_din = DW'(nbytes * 37 + 11);
                        exp_rd.push_back(bus_din);
                    end
                end
            end else if (bus_busy) begin
                if (nbytes != stuck_at) begin
                    if (hold > 1) hold--;
                    else begin bus_busy = 1'b0; fall_idx = cyc; end
                end
            end else if (pre_hold > 0) begin
                bus_busy = 1'b1; hold = pre_hold; pre_hold = 0;
            end
        end
        p_sop = bus_sop_n; p_stb = bus_stb_n; p_rnw = bus_rnw;
        p_dout = bus_dout; p_doe = bus_doe;
    end

    task automatic run_op(input bit rd, input int n, input int d, input int h,
                          input bit e, input int stuck_rel, input int pre, input string tag);
        logic [DW-1:0] sent[$];
        int s0, p0, ecnt;
        bit stk;
        @(negedge clk);
        stk = (stuck_rel > 0);
        dly_cfg = d; hold_cfg = h; bus_error = e; exp_tmo = 0;
        rx.delete();
        stuck_at = stk ? nbytes + stuck_rel : -1;
        pre_hold = pre;
        s0 = nstb; p0 = npop;
        if (!rd) for (int k = 0; k < n; k++) begin
            sent.push_back(DW'(k * 29 + 5));
            wr_q.push_back(DW'(k * 29 + 5));
        end
        req_valid = 1'b1; req_read = rd; req_count = CW'(n);
        forever begin
            @(negedge clk);
            if (!req_ready) break;
        end
        req_valid = 1'b0;
        while (!done) @(negedge clk);
        ecnt = stk ? stuck_rel - 1 : n;
        chk(done_count == CW'(ecnt), {tag, " count (R7/R8)"}, done_count, ecnt);
        chk(done_timeout == stk && exp_tmo == stk, {tag, " R7 timeout flag"}, done_timeout, stk);
        chk(done_err == e, {tag, " R8 error flag"}, done_err, e);
        chk(done_ok == (!stk && !e), {tag, " R8 ok flag"}, done_ok, !stk && !e);
        chk(bus_sop_n && bus_stb_n, {tag, " R6 lines released at done"}, bus_sop_n, 1);
        chk(nstb - s0 == (stk ? stuck_rel : n), {tag, " R6 strobe count"}, nstb - s0, stk ? stuck_rel : n);
        if (!rd) begin
            chk(npop - p0 == n, {tag, " R3 pop count"}, npop - p0, n);
            chk(rx.size() == n, {tag, " R3 bytes received"}, rx.size(), n);
            for (int k = 0; k < n && k < rx.size(); k++)
                chk(rx[k] == sent[k], {tag, " R3 byte order"}, rx[k], sent[k]);
        end
        stuck_at = -1; bus_error = 1'b0;
        exp_rd.delete(); wr_q.delete();
        repeat (12) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(bus_sop_n && bus_stb_n && !bus_rnw && !bus_doe && !done && req_ready,
            "R1 reset state", {bus_sop_n, bus_stb_n, bus_rnw, bus_doe, done, req_ready}, 6'b110001);
        rst_n = 1'b1;
        @(negedge clk);
        chk(bus_sop_n && bus_stb_n && req_ready, "R1 idle after reset", bus_sop_n, 1);
        run_op(0, 3, 1, 2, 0, 0, 0, "T1 write3");
        run_op(1, 4, 1, 3, 0, 0, 0, "T2 read4");
        run_op(0, 0, 1, 2, 0, 0, 0, "T3 empty R6");
        run_op(0, 2, 1, 1, 1, 0, 0, "T4 error R8");
        run_op(1, 4, 1, 2, 0, 2, 0, "T5 stuck R7");
        run_op(0, 2, 1, 2, 0, 0, 6, "T6 prebusy R2");
        run_op(1, 7, 3, 6, 0, 0, 0, "T7 slow read R5");
        run_op(0, 7, 2, 1, 0, 0, 0, "T8 full write R3");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog R1-R9 run hung actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule